// File: doc/BRIEF.md
# Four-Channel Compare-Match Timer

A 16-bit up-counter with four compare channels, each driving one output line and one sticky match flag. The counter advances on a count enable. That enable comes either from an internal divider of the system clock (divide by 1, 2, 4 or 8) or from rising edges of an external event input. The external input is first brought into the clock domain through a synchronizer.

A channel matches on a count enable when the counter equals that channel's compare value. Each output starts at a level that software programs. At every match the output flips, so the first match drives the complement of the programmed level. In clear mode, a channel-A match returns the counter to zero instead of letting it step on. In free mode the counter simply wraps.

Software uses a small register port. Writes take effect on the clock edge where `bus_we` is high. A read returns the addressed register on `bus_rdata` one clock after the address is presented.

Top module: `quad_match_timer`

## Requirements
- R1: After reset the control register reads 0, the counter starts from 0, every compare register reads 0xFFFF, and all outputs and flags are 0.
- R2: With clock select 0, 1, 2 or 3, the counter advances exactly once every 1, 2, 4 or 8 system clocks respectively.
- R3: With any clock select value of 4 to 7, the counter advances once for each rising edge of `evt_i`, seen after a two-stage synchronizer. It does not advance while `evt_i` is held steady.
- R4: With the clear bit set, a count enable that finds the counter equal to compare A loads 0 into the counter. The counter therefore cycles through 0 up to compare A.
- R5: With the clear bit at 0, the counter steps past compare A and wraps from 0xFFFF to 0x0000.
- R6: The control register (address 0) holds the clear enable in bit 7 and the clock select in bits 6:4. Bits 3:0 hold the initial levels, with bit 0 for channel A through bit 3 for channel D. It reads back unchanged.
- R7: Every write to the control register loads each output from its initial-level bit on that clock edge.
- R8: Every compare match inverts that channel's output. The first match after a control write therefore shows the complement of the initial level.
- R9: A compare match sets the channel's flag; `match_flag` and address 6 bits 3:0 (bit 0 = A) show it. Writing 1 to a flag bit at address 6 clears it, and writing 0 leaves it unchanged.
- R10: The register map is as follows. Address 1 is the counter, which can be read and written. Addresses 2 to 5 hold compare A to D. Address 7 reads 0. Read data appears one clock after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| evt_i | input | 1 | External event input (asynchronous) |
| cmp_out | output | 4 | Compare outputs, bit 0 = channel A |
| match_flag | output | 4 | Sticky match flags, bit 0 = channel A |

## Verification
The assertions assume a few things about the inputs. Register writes arrive as single strobes. A register write always takes priority over a count enable landing on the same edge. Every level of `evt_i` lasts at least one clock, so the synchronizer sees each edge.

The bench holds every event level for two clocks. It sets up compare values while the clock select points at the external input with `evt_i` low, so the counter stays idle during setup. Counting then starts with the control write that reloads the outputs. From there the expected counter value, output levels and flags follow directly from the number of elapsed clocks.

// File: rtl/qmt_pkg.sv
package qmt_pkg;
  localparam int NUM_CH = 4;
  localparam int ADDR_W = 3;

  typedef struct packed {
    logic              clr_on_a;
    logic [2:0]        clk_sel;
    logic [NUM_CH-1:0] init_lvl;
  } ctrl_t;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMP0 = 3'd2;
  localparam logic [ADDR_W-1:0] A_FLAG = 3'd6;
endpackage

// File: rtl/qmt_tick_gen.sv
module qmt_tick_gen #(
  parameter int DIV_W  = 3,
  parameter int SYNC_N = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] clk_sel,
  input  logic       evt_i,
  output logic       tick_o
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] tap_mask;
  logic [SYNC_N:0]  evt_sh;
  logic             div_tick;
  logic             evt_edge;

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= div_q + 1'b1;
  end

  // low clk_sel bits pick how many divider bits must be all ones
  always_comb tap_mask = DIV_W'((32'd1 << clk_sel[1:0]) - 32'd1);
  assign div_tick = &(div_q | ~tap_mask);

  always_ff @(posedge clk) begin
    if (rst) evt_sh <= '0;
    else     evt_sh <= {evt_sh[SYNC_N-1:0], evt_i};
  end

  assign evt_edge = evt_sh[SYNC_N-1] & ~evt_sh[SYNC_N];
  assign tick_o   = clk_sel[2] ? evt_edge : div_tick;

  assert_edge_single_R3: assert property (@(posedge clk) disable iff (rst)
    evt_edge |=> !evt_edge);

  assert_div_spacing_R2: assert property (@(posedge clk) disable iff (rst)
    (div_tick && clk_sel[1:0] != 2'd0) |=> (!div_tick || clk_sel[1:0] == 2'd0));
endmodule

// File: rtl/qmt_counter.sv
module qmt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             clr_on_a,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst)                           cnt_q <= '0;
    else if (wr_en)                    cnt_q <= wr_data;
    else if (tick) begin
      if (clr_on_a && cnt_q == cmp_a)  cnt_q <= '0;
      else                             cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_clear_on_a_R4: assert property (@(posedge clk) disable iff (rst)
    (tick && clr_on_a && cnt_q == cmp_a && !wr_en) |=> (cnt_q == '0));

  assert_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (tick && !clr_on_a && cnt_q == CNT_MAX && !wr_en) |=> (cnt_q == '0));

  assert_free_step_R5: assert property (@(posedge clk) disable iff (rst)
    (tick && !clr_on_a && cnt_q != CNT_MAX && !wr_en) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/qmt_channel.sv
module qmt_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] wdata,
  input  logic             reload,
  input  logic             init_lvl,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cmp_q,
  output logic             out_q,
  output logic             flag_q
);
  logic match;

  always_ff @(posedge clk) begin
    if (rst)         cmp_q <= '1;
    else if (cmp_we) cmp_q <= wdata;
  end

  assign match = tick && (cnt == cmp_q);

  always_ff @(posedge clk) begin
    if (rst)         out_q <= 1'b0;
    else if (reload) out_q <= init_lvl;
    else if (match)  out_q <= ~out_q;
  end

  always_ff @(posedge clk) begin
    if (rst)           flag_q <= 1'b0;
    else if (match)    flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  assert_reload_R7: assert property (@(posedge clk) disable iff (rst)
    reload |=> (out_q == $past(init_lvl)));

  assert_toggle_R8: assert property (@(posedge clk) disable iff (rst)
    (match && !reload) |=> (out_q != $past(out_q)));

  assert_flag_set_R9: assert property (@(posedge clk) disable iff (rst)
    match |=> flag_q);
endmodule

// File: rtl/quad_match_timer.sv
module quad_match_timer
  import qmt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DIV_W  = 3,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic              evt_i,
  output logic [NUM_CH-1:0] cmp_out,
  output logic [NUM_CH-1:0] match_flag
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t            ctrl_q;
  logic             tick;
  logic             ctrl_wr;
  logic             cnt_wr;
  logic             flag_wr;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cmp_arr [NUM_CH];

  assign ctrl_wr = bus_we && (bus_addr == A_CTRL);
  assign cnt_wr  = bus_we && (bus_addr == A_CNT);
  assign flag_wr = bus_we && (bus_addr == A_FLAG);

  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
  end

  qmt_tick_gen #(.DIV_W(DIV_W), .SYNC_N(SYNC_N)) u_tick (
    .clk(clk), .rst(rst), .clk_sel(ctrl_q.clk_sel), .evt_i(evt_i), .tick_o(tick)
  );

  qmt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .clr_on_a(ctrl_q.clr_on_a),
    .cmp_a(cmp_arr[0]), .wr_en(cnt_wr), .wr_data(bus_wdata), .cnt_q(cnt_q)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    qmt_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst(rst), .tick(tick), .cnt(cnt_q),
      .cmp_we(bus_we && (bus_addr == ADDR_W'(int'(A_CMP0) + i))),
      .wdata(bus_wdata), .reload(ctrl_wr), .init_lvl(bus_wdata[i]),
      .flag_clr(flag_wr && bus_wdata[i]),
      .cmp_q(cmp_arr[i]), .out_q(cmp_out[i]), .flag_q(match_flag[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      case (bus_addr)
        A_CTRL:  bus_rdata <= CNT_W'(ctrl_q);
        A_CNT:   bus_rdata <= cnt_q;
        A_FLAG:  bus_rdata <= CNT_W'(match_flag);
        3'd2:    bus_rdata <= cmp_arr[0];
        3'd3:    bus_rdata <= cmp_arr[1];
        3'd4:    bus_rdata <= cmp_arr[2];
        3'd5:    bus_rdata <= cmp_arr[3];
        default: bus_rdata <= '0;
      endcase
    end
  end

  assert_ctrl_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !ctrl_wr |=> $stable(ctrl_q));
endmodule

// File: tb/sim_quad_match_timer.sv
module sim_quad_match_timer;
  import qmt_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        evt_i = 1'b0;
  logic [3:0]  cmp_out;
  logic [3:0]  match_flag;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_match_timer u0 (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_i(evt_i),
    .cmp_out(cmp_out), .match_flag(match_flag)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a;
    @(posedge clk); #1 d = bus_rdata;
    @(negedge clk);
  endtask

  function automatic int nmatch(int m, int r, int p);
    if (r >= p || r >= m) return 0;
    return (m - 1 - r) / p + 1;
  endfunction

  task automatic run_match(input bit clr, input logic [3:0] init, input int ca, input int cb,
                           input int cc, input int cd, input int m);
    int cmpv [4];
    int p;
    int n;
    logic [3:0] eo;
    logic [3:0] ef;
    logic [15:0] v;
    cmpv = '{ca, cb, cc, cd};
    p = clr ? ca + 1 : 65536;
    wr(A_CTRL, 16'h0040);
    for (int i = 0; i < 4; i++) wr(3'(int'(A_CMP0) + i), 16'(cmpv[i]));
    wr(A_CNT, 16'h0000);
    wr(A_FLAG, 16'h000F);
    wr(A_CTRL, {8'h00, clr, 3'b000, init});
    chk("R7 outputs after control write", cmp_out, init);
    repeat (m) @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      n = nmatch(m, cmpv[i], p);
      eo[i] = init[i] ^ n[0];
      ef[i] = (n > 0);
    end
    chk("R8 outputs after matches", cmp_out, eo);
    chk("R9 match flags", match_flag, ef);
    rd(A_CNT, v);
    chk(clr ? "R4 counter in clear mode" : "R5 counter in free mode", v, 16'(m % p));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [15:0] f1;
    int np;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(A_CNT, v);         chk("R1 counter", v, 16'h0000);
    chk("R1 outputs", cmp_out, 4'h0);
    chk("R1 flags", match_flag, 4'h0);
    rd(A_CTRL, v);        chk("R1 control", v, 16'h0000);
    rd(3'd3, v);          chk("R1 compare B", v, 16'hFFFF);

    // R2 internal divider
    for (int s = 0; s < 4; s++) begin
      wr(A_CTRL, 16'(s << 4));
      wr(A_CNT, 16'h0000);
      repeat (40) @(posedge clk);
      @(negedge clk);
      rd(A_CNT, v);
      chk("R2 divided count", v, 16'(40 >> s));
    end

    // R3 external events
    wr(A_CTRL, 16'(16'h0040 | (($urandom % 4) << 4)));
    wr(A_CNT, 16'h0000);
    np = 3 + ($urandom % 8);
    for (int k = 0; k < np; k++) begin
      evt_i = 1'b1; repeat (2) @(negedge clk);
      evt_i = 1'b0; repeat (2) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    rd(A_CNT, v);
    chk("R3 event count", v, 16'(np));
    repeat (5) @(negedge clk);
    rd(A_CNT, v);
    chk("R3 steady input holds count", v, 16'(np));

    // R5 wrap
    wr(A_CTRL, 16'h0000);
    wr(A_CNT, 16'hFFFD);
    repeat (5) @(posedge clk);
    @(negedge clk);
    rd(A_CNT, v);
    chk("R5 wrap", v, 16'h0002);

    // R6 layout and read-back
    wr(A_CTRL, 16'h00C5);
    rd(A_CTRL, v);
    chk("R6 control read-back", v, 16'h00C5);
    chk("R6 init bit order", cmp_out, 4'b0101);

    // R10 map
    wr(3'd5, 16'h1234);
    rd(3'd5, v);  chk("R10 compare D read", v, 16'h1234);
    rd(3'd7, v);  chk("R10 unused address", v, 16'h0000);

    // directed matches
    run_match(1'b1, 4'b1010, 0, 0, 1, 2, 7);
    run_match(1'b0, 4'b0011, 5, 19, 20, 3, 20);
    run_match(1'b1, 4'b0000, 9, 4, 9, 12, 35);

    // R9 write-one-to-clear
    wr(A_CTRL, 16'h0040);
    rd(A_FLAG, f1);
    chk("R9 flags before clear", f1, 16'h0007);
    wr(A_FLAG, 16'h0005);
    rd(A_FLAG, v);
    chk("R9 cleared bits", v, 16'h0002);
    chk("R9 flag port", match_flag, 4'b0010);
    wr(A_FLAG, 16'h0000);
    rd(A_FLAG, v);
    chk("R9 zero write no effect", v, 16'h0002);

    // random matches
    for (int t = 0; t < 12; t++) begin
      run_match(1'($urandom % 2), 4'($urandom), int'($urandom % 21),
                int'($urandom % 41), int'($urandom % 41), int'($urandom % 41),
                5 + int'($urandom % 86));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule